// File: doc/BRIEF.md
# Dual-Address Remapped Data Cache

This block is a direct-mapped data cache for loads in which line placement is chosen by software. Every load request carries a real address, which is the true location in memory, and may also carry a mapping address. The mapping address picks the cache entry: both its index and its tag come from the mapping address. Any memory traffic uses only the real address. Software can therefore place two arrays that would collide in the cache into different entries. It does this by shifting one stream's mapping address by a line size, while the data still comes from the arrays' true locations. When no mapping address is supplied, the real address plays both roles and the block behaves as a plain direct-mapped cache.

Each entry holds three things: the mapping tag, the line-aligned real address that the entry was filled from, and the line data. A lookup hits only when both the mapping tag and the stored real line match the request. A hit answers one cycle after acceptance, with the same latency whether or not a mapping address is used. A miss goes through a small fill sequence. The block asks memory for the whole line at the aligned real address, waits for it, writes it into the entry and then answers. Only one load is in flight at a time. The mapping address is never sent to memory, so it does not need to be a valid address.

Top module: `remap_dcache`

## Requirements
- R1: After reset every entry is invalid: reqReady is 1, rspValid and fillReqValid are 0, and the first load to any entry misses and issues a fill.
- R2: A load that hits returns rspValid one cycle after the cycle in which it was accepted, with the same latency with and without a mapping address.
- R3: With reqMapValid=1 the entry index and tag come from reqMapAddr. With reqMapValid=0 they come from reqRealAddr, so real addresses that are one cache size apart evict each other.
- R4: A miss issues exactly one fill request. Its fillReqAddr is the real address with the low log2(LINE_BYTES) bits cleared, and a mapping address never appears on the fill port.
- R5: A hit requires a valid entry whose mapping tag and stored real line both equal the request's. A matching mapping tag with a different real line is a miss that replaces the entry.
- R6: Word k of a line is fillRspData[WORD_W*k +: WORD_W]. rspData is the word selected by the real address bits [log2(LINE_BYTES)-1 : log2(WORD_W/8)].
- R7: From the cycle a miss is detected until its response is delivered, reqReady is 0. At most one accepted load is awaiting its response.
- R8: Two streams that conflict without remapping both stay resident when one stream's mapping address is offset by one line size, so repeated passes over both streams hit.
- R9: Once raised, fillReqValid and fillReqAddr hold steady until fillReqReady is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Load request present |
| reqReady | output | 1 | Block can accept a load this cycle |
| reqRealAddr | input | ADDR_W | Real byte address of the load |
| reqMapValid | input | 1 | reqMapAddr is supplied |
| reqMapAddr | input | ADDR_W | Mapping address that chooses the entry |
| rspValid | output | 1 | Load data valid |
| rspData | output | WORD_W | Loaded word |
| fillReqValid | output | 1 | Line fill request to memory |
| fillReqReady | input | 1 | Memory takes the fill request |
| fillReqAddr | output | ADDR_W | Line-aligned real address to fill |
| fillRspValid | input | 1 | Whole line returned by memory |
| fillRspData | input | LINE_BYTES*8 | Returned line data |

## Verification
The bench builds the cache with 16-byte lines and 8 entries, which gives a 128-byte capacity. With that size, real addresses that are 0x80 apart collide in a few loads. The bench uses that to produce a conflict, remove it with a one-line mapping offset, and force a replacement through a real-line mismatch under an identical mapping tag. Mapping addresses are drawn from a region that no real load uses, so any leak onto the fill port is visible, and four words per line make the word selection observable.

// File: rtl/remap_dcache_pkg.sv
package remap_dcache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_FILL_REQ  = 2'd1,
    ST_FILL_WAIT = 2'd2,
    ST_RESPOND   = 2'd3
  } ctrlState_t;

  // strobes from the controller to the datapath
  typedef struct packed {
    logic accept;     // capture a new load
    logic fillWrite;  // write returned line into the entry
    logic retire;     // response delivered, pending slot frees
  } ctrlStrobes_t;

endpackage

// File: rtl/remap_dcache_dp.sv
module remap_dcache_dp
  import remap_dcache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int NUM_LINES  = 512
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStrobes_t            strobes,
  input  logic [ADDR_W-1:0]       reqRealAddr,
  input  logic                    reqMapValid,
  input  logic [ADDR_W-1:0]       reqMapAddr,
  input  logic [LINE_BYTES*8-1:0] fillRspData,
  output logic                    pending,
  output logic                    lookupHit,
  output logic [WORD_W-1:0]       rspData,
  output logic [ADDR_W-1:0]       fillReqAddr
);

  localparam int WORD_BYTES = WORD_W / 8;
  localparam int LINE_W     = LINE_BYTES * 8;
  localparam int WORDS      = LINE_BYTES / WORD_BYTES;
  localparam int OFF_W      = $clog2(LINE_BYTES);
  localparam int BOFF_W     = $clog2(WORD_BYTES);
  localparam int WSEL_W     = $clog2(WORDS);
  localparam int IDX_W      = $clog2(NUM_LINES);
  localparam int TAG_W      = ADDR_W - OFF_W - IDX_W;
  localparam int RLINE_W    = ADDR_W - OFF_W;

  // line-granular mapping address: the real one when no mapping is given
  logic [RLINE_W-1:0] mapLineIn;
  assign mapLineIn = reqMapValid ? reqMapAddr[ADDR_W-1:OFF_W]
                                 : reqRealAddr[ADDR_W-1:OFF_W];

  logic [IDX_W-1:0]   pendIdx;
  logic [TAG_W-1:0]   pendTag;
  logic [RLINE_W-1:0] pendRealLine;
  logic [WSEL_W-1:0]  pendWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending      <= 1'b0;
      pendIdx      <= '0;
      pendTag      <= '0;
      pendRealLine <= '0;
      pendWord     <= '0;
    end else if (strobes.accept) begin
      pending      <= 1'b1;
      pendIdx      <= mapLineIn[IDX_W-1:0];
      pendTag      <= mapLineIn[RLINE_W-1:IDX_W];
      pendRealLine <= reqRealAddr[ADDR_W-1:OFF_W];
      pendWord     <= reqRealAddr[OFF_W-1:BOFF_W];
    end else if (strobes.retire) begin
      pending <= 1'b0;
    end
  end

  // entry state
  logic [NUM_LINES-1:0] validBits;
  logic [TAG_W-1:0]     tagMem  [NUM_LINES];
  logic [RLINE_W-1:0]   realMem [NUM_LINES];
  logic [LINE_W-1:0]    dataMem [NUM_LINES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validBits <= '0;
    end else if (strobes.fillWrite) begin
      validBits[pendIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.fillWrite) begin
      tagMem[pendIdx]  <= pendTag;
      realMem[pendIdx] <= pendRealLine;
      dataMem[pendIdx] <= fillRspData;
    end
  end

  // lookup: both the mapping tag and the real line must agree
  logic tagMatch;
  logic realMatch;
  assign tagMatch  = (tagMem[pendIdx] == pendTag);
  assign realMatch = (realMem[pendIdx] == pendRealLine);
  assign lookupHit = pending && validBits[pendIdx] && tagMatch && realMatch;

  // word selection within the stored line
  logic [LINE_W-1:0] curLine;
  logic [WORD_W-1:0] lineWords [WORDS];
  assign curLine = dataMem[pendIdx];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    assign lineWords[g] = curLine[g*WORD_W +: WORD_W];
  end

  assign rspData     = lineWords[pendWord];
  assign fillReqAddr = {pendRealLine, {OFF_W{1'b0}}};

  logic unusedLowBits;
  assign unusedLowBits = ^{reqRealAddr[BOFF_W-1:0], reqMapAddr[OFF_W-1:0]};

endmodule

// File: rtl/remap_dcache_ctrl.sv
module remap_dcache_ctrl
  import remap_dcache_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         pending,
  input  logic         lookupHit,
  input  logic         fillReqReady,
  input  logic         fillRspValid,
  output logic         reqReady,
  output logic         rspValid,
  output logic         fillReqValid,
  output ctrlStrobes_t strobes
);

  ctrlState_t state;
  ctrlState_t stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext         = state;
    reqReady          = 1'b0;
    rspValid          = 1'b0;
    fillReqValid      = 1'b0;
    strobes.fillWrite = 1'b0;
    strobes.retire    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        // a hit answers now and lets the next load in the same cycle
        reqReady       = !pending || lookupHit;
        rspValid       = pending && lookupHit;
        strobes.retire = pending && lookupHit;
        if (pending && !lookupHit) stateNext = ST_FILL_REQ;
      end
      ST_FILL_REQ: begin
        fillReqValid = 1'b1;
        if (fillReqReady) stateNext = ST_FILL_WAIT;
      end
      ST_FILL_WAIT: begin
        if (fillRspValid) begin
          strobes.fillWrite = 1'b1;
          stateNext         = ST_RESPOND;
        end
      end
      ST_RESPOND: begin
        rspValid       = 1'b1;
        strobes.retire = 1'b1;
        stateNext      = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
    strobes.accept = reqValid && reqReady;
  end

endmodule

// File: rtl/remap_dcache.sv
module remap_dcache
  import remap_dcache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int NUM_LINES  = 512
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  output logic                    reqReady,
  input  logic [ADDR_W-1:0]       reqRealAddr,
  input  logic                    reqMapValid,
  input  logic [ADDR_W-1:0]       reqMapAddr,
  output logic                    rspValid,
  output logic [WORD_W-1:0]       rspData,
  output logic                    fillReqValid,
  input  logic                    fillReqReady,
  output logic [ADDR_W-1:0]       fillReqAddr,
  input  logic                    fillRspValid,
  input  logic [LINE_BYTES*8-1:0] fillRspData
);

  ctrlStrobes_t strobes;
  logic         pending;
  logic         lookupHit;

  remap_dcache_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .pending      (pending),
    .lookupHit    (lookupHit),
    .fillReqReady (fillReqReady),
    .fillRspValid (fillRspValid),
    .reqReady     (reqReady),
    .rspValid     (rspValid),
    .fillReqValid (fillReqValid),
    .strobes      (strobes)
  );

  remap_dcache_dp #(
    .ADDR_W     (ADDR_W),
    .WORD_W     (WORD_W),
    .LINE_BYTES (LINE_BYTES),
    .NUM_LINES  (NUM_LINES)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .reqRealAddr  (reqRealAddr),
    .reqMapValid  (reqMapValid),
    .reqMapAddr   (reqMapAddr),
    .fillRspData  (fillRspData),
    .pending      (pending),
    .lookupHit    (lookupHit),
    .rspData      (rspData),
    .fillReqAddr  (fillReqAddr)
  );

endmodule

// File: rtl/remap_dcache_chk.sv
module remap_dcache_chk #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              rspValid,
  input logic              fillReqValid,
  input logic              fillReqReady,
  input logic [ADDR_W-1:0] fillReqAddr
);

  localparam int OFF_W = $clog2(LINE_BYTES);

  // accepted loads still waiting for their answer
  logic [1:0] inFlight;
  always_ff @(posedge clk) begin
    if (!rstN) inFlight <= '0;
    else inFlight <= inFlight + {1'b0, reqValid && reqReady} - {1'b0, rspValid};
  end

  // R7
  stall_on_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    fillReqValid |-> !reqReady);

  // R7
  single_outstanding_chk: assert property (@(posedge clk) disable iff (!rstN)
    inFlight <= 2'd1);

  // R1
  no_orphan_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> inFlight == 2'd1);

  // R4
  fill_aligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    fillReqValid |-> fillReqAddr[OFF_W-1:0] == '0);

  // R4
  fill_has_owner_chk: assert property (@(posedge clk) disable iff (!rstN)
    fillReqValid |-> inFlight == 2'd1);

  // R9
  fill_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    fillReqValid && !fillReqReady |=> fillReqValid && $stable(fillReqAddr));

endmodule

bind remap_dcache remap_dcache_chk #(
  .ADDR_W     (ADDR_W),
  .LINE_BYTES (LINE_BYTES)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .reqValid     (reqValid),
  .reqReady     (reqReady),
  .rspValid     (rspValid),
  .fillReqValid (fillReqValid),
  .fillReqReady (fillReqReady),
  .fillReqAddr  (fillReqAddr)
);

// File: tb/remap_dcache_tb.sv
module remap_dcache_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 32;
  localparam int WORD_W     = 32;
  localparam int LINE_BYTES = 16;
  localparam int NUM_LINES  = 8;
  localparam int LINE_W     = LINE_BYTES * 8;
  localparam int WORDS      = LINE_BYTES / (WORD_W / 8);

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqReady;
  logic [ADDR_W-1:0] reqRealAddr = '0;
  logic              reqMapValid = 1'b0;
  logic [ADDR_W-1:0] reqMapAddr = '0;
  logic              rspValid;
  logic [WORD_W-1:0] rspData;
  logic              fillReqValid;
  logic              fillReqReady = 1'b0;
  logic [ADDR_W-1:0] fillReqAddr;
  logic              fillRspValid = 1'b0;
  logic [LINE_W-1:0] fillRspData = '0;

  int total = 0;
  int bad = 0;
  int fillCount = 0;
  bit finished = 1'b0;

  logic [WORD_W-1:0] expData[$];
  string             expTag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  remap_dcache #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINE_BYTES(LINE_BYTES), .NUM_LINES(NUM_LINES)
  ) u_dut (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady),
    .reqRealAddr(reqRealAddr), .reqMapValid(reqMapValid), .reqMapAddr(reqMapAddr),
    .rspValid(rspValid), .rspData(rspData),
    .fillReqValid(fillReqValid), .fillReqReady(fillReqReady), .fillReqAddr(fillReqAddr),
    .fillRspValid(fillRspValid), .fillRspData(fillRspData)
  );

  function automatic logic [WORD_W-1:0] memWord(input logic [ADDR_W-1:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h0BAD_1234;
  endfunction

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // memory model: stalls each fill request, checks the request, returns the line
  initial begin
    forever begin
      @(negedge clk);
      if (fillReqValid) begin
        logic [ADDR_W-1:0] a;
        a = fillReqAddr;
        check(a[$clog2(LINE_BYTES)-1:0] == '0, "R4", "fill address aligned", a, a & ~(LINE_BYTES-1));
        check(a[31:28] != 4'hF, "R4", "fill uses real address", a, 0);
        for (int s = 0; s < 2; s++) begin
          @(negedge clk);
          check(fillReqValid && fillReqAddr == a, "R9", "fill request held",
                {31'b0, fillReqValid, fillReqAddr}, {32'd1, a});
        end
        fillReqReady = 1'b1;
        @(negedge clk);
        fillReqReady = 1'b0;
        fillCount++;
        repeat (3) @(negedge clk);
        for (int k = 0; k < WORDS; k++) fillRspData[k*WORD_W +: WORD_W] = memWord(a + 4*k);
        fillRspValid = 1'b1;
        @(negedge clk);
        fillRspValid = 1'b0;
      end
    end
  end

  // monitor: compares each response with the scoreboard queue
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      if (expData.size() == 0) begin
        check(1'b0, "R7", "unexpected response", rspData, 0);
      end else begin
        logic [WORD_W-1:0] e;
        string t;
        e = expData.pop_front();
        t = expTag.pop_front();
        check(rspData == e, t, "load data", rspData, e);
      end
    end
  end

  // driver: one load; the expected word pushed, latency and fill count checked
  task automatic doLoad(input logic [ADDR_W-1:0] ra, input bit mv, input logic [ADDR_W-1:0] ma,
                        input bit expHit, input string rq);
    int cycles;
    int fillsBefore;
    bit readyLow;
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqRealAddr = ra; reqMapValid = mv; reqMapAddr = ma;
    fillsBefore = fillCount;
    expData.push_back(memWord(ra));
    expTag.push_back(rq);
    @(negedge clk);
    reqValid = 1'b0; reqMapValid = 1'b0;
    cycles = 1;
    readyLow = 1'b1;
    while (!rspValid) begin
      if (reqReady) readyLow = 1'b0;
      @(negedge clk);
      cycles++;
    end
    if (expHit) begin
      check(cycles == 1, rq, "hit latency", cycles, 1);
      check(fillCount == fillsBefore, rq, "no fill on hit", fillCount - fillsBefore, 0);
    end else begin
      check(cycles > 1, rq, "miss latency", cycles, 2);
      check(fillCount == fillsBefore + 1, rq, "one fill per miss", fillCount - fillsBefore, 1);
      check(readyLow, "R7", "ready low during miss", readyLow, 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1, "R1", "ready after reset", reqReady, 1);
    check(rspValid == 1'b0, "R1", "no response after reset", rspValid, 0);
    check(fillReqValid == 1'b0, "R1", "no fill after reset", fillReqValid, 0);

    // R1 cold miss, R2/R6 hits on other words of the same line
    doLoad(32'h100, 0, 0, 0, "R1");
    doLoad(32'h104, 0, 0, 1, "R6");
    doLoad(32'h10C, 0, 0, 1, "R2");
    // R3 conflict without mapping: 0x180 shares the entry of 0x100
    doLoad(32'h180, 0, 0, 0, "R3");
    doLoad(32'h100, 0, 0, 0, "R3");
    // R8 remap stream B one line over, mapping in an unused region
    doLoad(32'h200, 1, 32'h200, 0, "R8");
    doLoad(32'h280, 1, 32'hF000_0290, 0, "R4");
    for (int p = 0; p < 2; p++) begin
      doLoad(32'h204 + 8*p, 1, 32'h204 + 8*p, 1, "R8");
      doLoad(32'h284 + 8*p, 1, 32'hF000_0294 + 8*p, 1, "R8");
    end
    // R2 same latency with a mapping address
    doLoad(32'h288, 1, 32'hF000_0298, 1, "R2");
    // R5 same mapping tag, different real line: miss and replace
    doLoad(32'h300, 1, 32'h200, 0, "R5");
    doLoad(32'h308, 1, 32'h200, 1, "R5");
    doLoad(32'h200, 1, 32'h200, 0, "R5");
    // R3 the mapping address alone chooses the entry
    doLoad(32'h400, 1, 32'hF000_0010, 0, "R3");
    doLoad(32'h404, 0, 0, 0, "R3");
    doLoad(32'h408, 1, 32'hF000_0018, 1, "R3");

    repeat (4) @(negedge clk);
    check(expData.size() == 0, "R7", "all responses seen", expData.size(), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule